// File: doc/BRIEF.md
# Last Received Command Holding Register

This block sits beside the word decoder of a serial-bus remote terminal. It keeps a copy of the most recent 16-bit command word so that a host processor can read it at any time. The copy is taken on the cycle in which the decoder pulses its command strobe. There is one exception: a command that asks the terminal to send back its previous command does not replace the stored word, because that earlier word is the thing being requested.

The host reads through a small synchronous port. The port has a chip select, a control strobe, a read/write line and one address bit. The address bit chooses between this register and a neighbouring system register, and that system register's value arrives on an input. A read request is answered on the cycle after it is made. The answer appears on a data output that is driven at all times and is zero when no read was requested.

Top module: `last_cmd_reg`

## Requirements
- R1: After reset the held command word is zero, `rd_valid` is 0 and `rd_data` is zero.
- R2: In a cycle with `cmd_strobe` high, and unless R3 applies, the held word becomes `cmd_word`. A read of the register afterwards returns it.
- R3: A strobed word that has bit 10 (transmit flag) at 1, bits 9..5 (subaddress) equal to 0 or 31, and bits 4..0 (mode field) equal to 18 is not loaded. The previous held word stays.
- R4: A strobed word that differs from the R3 pattern in any one of the transmit flag, subaddress or mode field is loaded normally.
- R5: When `host_cs`, `host_ctrl` and `host_rd_wr` are all 1 and `host_addr_lsb` is 1, the next cycle shows `rd_valid`=1, `rd_is_last`=1 and `rd_data` equal to the held word.
- R6: When `host_cs`, `host_ctrl` and `host_rd_wr` are all 1 and `host_addr_lsb` is 0, the next cycle shows `rd_valid`=1, `rd_is_last`=0 and `rd_data` equal to `sys_word` as sampled on the request cycle.
- R7: If any of `host_cs`, `host_ctrl` or `host_rd_wr` is 0, the next cycle shows `rd_valid`=0, `rd_is_last`=0 and `rd_data`=0.
- R8: If a load and a last-command read fall in the same cycle, the read returns the word held before that load.
- R9: Host accesses of any kind never change the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_strobe | input | 1 | One-cycle pulse marking a decoded command word |
| cmd_word | input | 16 | Command word presented with the strobe |
| host_cs | input | 1 | Host chip select, active high |
| host_ctrl | input | 1 | Host control strobe, active high |
| host_rd_wr | input | 1 | 1 = read |
| host_addr_lsb | input | 1 | 1 selects the last-command register, 0 selects the system register |
| sys_word | input | 16 | Current system register value |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_is_last | output | 1 | The returned word came from the last-command register |
| rd_data | output | 16 | Read data, zero when no read is returned |

## Verification
A command strobe and a host read of the last-command register can fall in the same clock cycle. The bench provokes this by raising the strobe and the full read handshake together. Each time, it strobes a word that differs from the one currently held. It then requires the returned data to equal the previously held word, and a second read on the next cycle to show the new word. The same collision is repeated with a suppressed transmit-last-command word. In that case both reads must return the old word.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  localparam int WORD_W    = 16;
  localparam int TR_POS    = 10;
  localparam int SUB_LSB   = 5;
  localparam int FIELD_W   = 5;
  localparam int MODE_LSB  = 0;
  localparam logic [FIELD_W-1:0] MODE_TX_LAST = 5'd18;
  localparam logic [FIELD_W-1:0] SUB_MODE_LO  = 5'd0;
  localparam logic [FIELD_W-1:0] SUB_MODE_HI  = 5'd31;

  typedef logic [WORD_W-1:0] word_t;

  function automatic logic tr_flag(input word_t w);
    return w[TR_POS];
  endfunction

  function automatic logic [FIELD_W-1:0] sub_field(input word_t w);
    return w[SUB_LSB +: FIELD_W];
  endfunction

  function automatic logic [FIELD_W-1:0] mode_field(input word_t w);
    return w[MODE_LSB +: FIELD_W];
  endfunction

  function automatic logic is_mode_cmd(input word_t w);
    return (sub_field(w) == SUB_MODE_LO) || (sub_field(w) == SUB_MODE_HI);
  endfunction

  function automatic logic is_tx_last(input word_t w);
    return tr_flag(w) && is_mode_cmd(w) && (mode_field(w) == MODE_TX_LAST);
  endfunction
endpackage

// File: rtl/lcr_cmd_filter.sv
module lcr_cmd_filter
  import lcr_pkg::*;
(
  input  logic  strobe,
  input  word_t word,
  output logic  load_en,
  output logic  skip_seen
);
  logic tx_last;

  always_comb begin
    tx_last   = is_tx_last(word);
    load_en   = strobe && !tx_last;
    skip_seen = strobe && tx_last;
  end
endmodule

// File: rtl/lcr_hold_reg.sv
module lcr_hold_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= d;
  end
endmodule

// File: rtl/lcr_host_port.sv
module lcr_host_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         ctrl,
  input  logic         rd_wr,
  input  logic         addr_lsb,
  input  logic [W-1:0] last_q,
  input  logic [W-1:0] sys_q,
  output logic         acc_last,
  output logic         acc_sys,
  output logic         rd_valid,
  output logic         rd_is_last,
  output logic [W-1:0] rd_data
);
  logic         rd_req;
  logic [W-1:0] sel_word;

  always_comb begin
    rd_req   = cs && ctrl && rd_wr;
    acc_last = rd_req && addr_lsb;
    acc_sys  = rd_req && !addr_lsb;
    sel_word = acc_last ? last_q : (acc_sys ? sys_q : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_is_last <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_valid   <= rd_req;
      rd_is_last <= acc_last;
      rd_data    <= sel_word;
    end
  end
endmodule

// File: rtl/last_cmd_reg.sv
module last_cmd_reg
  import lcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_strobe,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              host_cs,
  input  logic              host_ctrl,
  input  logic              host_rd_wr,
  input  logic              host_addr_lsb,
  input  logic [WORD_W-1:0] sys_word,
  output logic              rd_valid,
  output logic              rd_is_last,
  output logic [WORD_W-1:0] rd_data
);
  logic  load_fire;
  logic  load_skip;
  logic  acc_last;
  logic  acc_sys;
  word_t held_q;

  lcr_cmd_filter u_filter (
    .strobe    (cmd_strobe),
    .word      (cmd_word),
    .load_en   (load_fire),
    .skip_seen (load_skip)
  );

  lcr_hold_reg #(.W(WORD_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_fire),
    .d       (cmd_word),
    .q       (held_q)
  );

  lcr_host_port #(.W(WORD_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (host_cs),
    .ctrl       (host_ctrl),
    .rd_wr      (host_rd_wr),
    .addr_lsb   (host_addr_lsb),
    .last_q     (held_q),
    .sys_q      (sys_word),
    .acc_last   (acc_last),
    .acc_sys    (acc_sys),
    .rd_valid   (rd_valid),
    .rd_is_last (rd_is_last),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/last_cmd_reg_chk.sv
module last_cmd_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_strobe,
  input logic [15:0] cmd_word,
  input logic        host_cs,
  input logic        host_ctrl,
  input logic        host_rd_wr,
  input logic        host_addr_lsb,
  input logic [15:0] sys_word,
  input logic        load_fire,
  input logic        load_skip,
  input logic        acc_last,
  input logic        acc_sys,
  input logic [15:0] held_q,
  input logic        rd_valid,
  input logic        rd_is_last,
  input logic [15:0] rd_data
);
  logic req;
  logic tlc_pat;
  assign req     = host_cs && host_ctrl && host_rd_wr;
  assign tlc_pat = cmd_word[10] && (cmd_word[4:0] == 5'd18) &&
                   ((cmd_word[9:5] == 5'd0) || (cmd_word[9:5] == 5'd31));

  AST_LOAD_TAKES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> held_q == $past(cmd_word)); // R2

  AST_TLC_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && tlc_pat) |-> (!load_fire && load_skip)); // R3

  AST_OTHER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && !tlc_pat) |-> load_fire); // R4

  AST_LAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req && host_addr_lsb) |=> (rd_valid && rd_is_last && rd_data == $past(held_q))); // R5

  AST_SYS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !host_addr_lsb) |=> (rd_valid && !rd_is_last && rd_data == $past(sys_word))); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!rd_valid && !rd_is_last && rd_data == '0)); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> $stable(held_q)); // R9

  AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_last, acc_sys})); // R6
endmodule

bind last_cmd_reg last_cmd_reg_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_strobe    (cmd_strobe),
  .cmd_word      (cmd_word),
  .host_cs       (host_cs),
  .host_ctrl     (host_ctrl),
  .host_rd_wr    (host_rd_wr),
  .host_addr_lsb (host_addr_lsb),
  .sys_word      (sys_word),
  .load_fire     (load_fire),
  .load_skip     (load_skip),
  .acc_last      (acc_last),
  .acc_sys       (acc_sys),
  .held_q        (held_q),
  .rd_valid      (rd_valid),
  .rd_is_last    (rd_is_last),
  .rd_data       (rd_data)
);

// File: tb/last_cmd_reg_bench.sv
module last_cmd_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_strobe = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        host_cs = 1'b0;
  logic        host_ctrl = 1'b0;
  logic        host_rd_wr = 1'b0;
  logic        host_addr_lsb = 1'b0;
  logic [15:0] sys_word = '0;
  logic        rd_valid;
  logic        rd_is_last;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;
  logic [15:0] model_held = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  last_cmd_reg u_last_cmd_reg (
    .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_word(cmd_word),
    .host_cs(host_cs), .host_ctrl(host_ctrl), .host_rd_wr(host_rd_wr),
    .host_addr_lsb(host_addr_lsb), .sys_word(sys_word),
    .rd_valid(rd_valid), .rd_is_last(rd_is_last), .rd_data(rd_data)
  );

  // Suppressed pattern restated arithmetically: transmit flag at 2^10,
  // subaddress = (w / 32) % 32 in {0,31}, mode = w % 32 == 18.
  function automatic bit tlc(input logic [15:0] w);
    int v;
    v = int'(w);
    return ((v / 1024) % 2 == 1) && (((v / 32) % 32 == 0) || ((v / 32) % 32 == 31))
           && (v % 32 == 18);
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive on negedge, sample after posedge, then advance model.
  task automatic step(input string req, input bit stb, input logic [15:0] w,
                      input bit cs, input bit ct, input bit rw, input bit lsb,
                      input logic [15:0] sw);
    logic [17:0] exp;
    @(negedge clk);
    cmd_strobe = stb; cmd_word = w; host_cs = cs; host_ctrl = ct;
    host_rd_wr = rw; host_addr_lsb = lsb; sys_word = sw;
    if (cs && ct && rw) exp = {1'b1, lsb, lsb ? model_held : sw};
    else                exp = '0;
    @(posedge clk); #1;
    check(req, {rd_valid, rd_is_last, rd_data}, exp);
    if (stb && !tlc(w)) model_held = w;
    @(negedge clk);
    cmd_strobe = 1'b0; host_cs = 1'b0; host_ctrl = 1'b0; host_rd_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    check("R1", {rd_valid, rd_is_last, rd_data}, '0);
    @(negedge clk); rst_n = 1'b1;
    step("R1", 0, 16'h0, 1, 1, 1, 1, 16'hFFFF);

    // R2 R3 R4: sweep transmit flag x subaddress x mode field, then read back.
    for (int tr = 0; tr < 2; tr++)
      for (int sa = 0; sa < 32; sa++)
        for (int md = 0; md < 32; md++) begin
          logic [15:0] w;
          w = 16'((sa * 7 + md) % 32 * 2048 + tr * 1024 + sa * 32 + md);
          step(tlc(w) ? "R3" : "R4", 1, w, 0, 0, 0, 0, 16'h0);
          step("R2", 0, 16'h0, 1, 1, 1, 1, 16'h0);
        end

    // R6 R7 R9: all 16 handshake combinations, with held word checked after.
    step("R2", 1, 16'hA5C3, 0, 0, 0, 0, 16'h0);
    for (int k = 0; k < 16; k++) begin
      bit cs, ct, rw, lsb;
      {cs, ct, rw, lsb} = 4'(k);
      step((cs && ct && rw) ? (lsb ? "R5" : "R6") : "R7", 0, 16'h0,
           cs, ct, rw, lsb, 16'(k * 4369 + 1));
      step("R9", 0, 16'h0, 1, 1, 1, 1, 16'h0);
    end

    // R8: collision of load and last-command read.
    for (int n = 0; n < 8; n++) begin
      logic [15:0] w;
      w = 16'(n * 8191 + 3);
      if (tlc(w)) w = w ^ 16'h0400;
      step("R8", 1, w, 1, 1, 1, 1, 16'h0);
      step("R8", 0, 16'h0, 1, 1, 1, 1, 16'h0);
    end
    // R8 with suppressed word colliding: both reads keep old word.
    step("R8", 1, 16'h7C12, 1, 1, 1, 1, 16'h0);
    step("R3", 1, 16'h0412, 1, 1, 1, 1, 16'h0);
    step("R3", 0, 16'h0, 1, 1, 1, 1, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule